// File: doc/BRIEF.md
# Direct-Mapped Look-Aside Read Cache

This block is a direct-mapped cache placed beside main memory on a shared processor bus. Every accepted processor request is driven onto the memory side in the same cycle, so memory always starts the bus cycle in parallel with the cache lookup. When the lookup hits on a read, the cache answers one cycle later and raises an abort so that memory drops the cycle. When the lookup misses, the processor waits until memory returns the whole line. That returning line is handed to the processor and written into the cache in the same cycle.

Each line holds one block of `LINE_BYTES` bytes, a tag and a valid bit. The low address bits pick the byte within the line, the next bits pick the line, and the remaining upper bits form the tag. Writes carry a single byte and always go through to memory. A write updates the cached byte only when the line is already present, and a write miss does not allocate a line. Only one request is in flight at a time. The block accepts a request only while it is idle. The defaults are 1024 lines of 4 bytes and a 24-bit address. The line count is a parameter, and setting `LINES` to 16384 gives a 64 KiB store.

Top module: `cache_lookaside_dm`

## Requirements
- R1: After reset every line is invalid. `p_ready` is 1, and `p_rvalid` and `m_abort` are 0. The first read of any address is a miss.
- R2: Address bits [1:0] select the byte, bits [11:2] select the line and bits [23:12] are the tag (defaults). Two addresses that differ only in bits [1:0] use the same line.
- R3: A read hit drives `p_rvalid` high for one cycle, exactly one cycle after the request is accepted. In that cycle `p_rdata` holds the cached line and `m_abort` is 1.
- R4: On a read miss `p_rvalid` stays 0 until `m_line_valid` is 1. In that cycle `p_rvalid` is 1, `p_rdata` equals `m_line` and `m_abort` is 0.
- R5: A line filled by a miss makes later reads of that line hit and return the filled data.
- R6: Two addresses with the same line index and different tags evict each other, so alternating reads between them miss every time.
- R7: In the cycle a request is accepted (`p_req` and `p_ready` both 1), `m_req` is 1 and `m_addr` equals `p_addr`.
- R8: A write (`p_we`=1) is forwarded to memory with `m_we`=1 and `m_wbyte`=`p_wbyte`, and it produces no `p_rvalid` and no `m_abort`. On a write hit, the byte at offset `p_addr[1:0]` of the cached line, which is bits [8*offset+7 : 8*offset], is replaced.
- R9: A write miss does not allocate a line, so a following read of that address misses.
- R10: `p_ready` is 0 from the cycle after acceptance until the request completes. A `p_req` presented while `p_ready` is 0 is ignored and raises no `m_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all valid bits |
| p_req | input | 1 | Processor request strobe |
| p_we | input | 1 | 1 = byte write, 0 = line read |
| p_addr | input | ADDR_W | Processor byte address |
| p_wbyte | input | 8 | Write data byte |
| p_ready | output | 1 | Block idle, a request is accepted this cycle |
| p_rvalid | output | 1 | Read data valid |
| p_rdata | output | 8*LINE_BYTES | Read line data |
| m_req | output | 1 | Memory bus cycle start |
| m_we | output | 1 | Memory cycle is a write |
| m_addr | output | ADDR_W | Memory address |
| m_wbyte | output | 8 | Memory write byte |
| m_abort | output | 1 | Terminates the memory read cycle on a hit |
| m_line_valid | input | 1 | Memory returns a line this cycle |
| m_line | input | 8*LINE_BYTES | Returned line data |

## Verification
Two pairs of events are required to fall in the same cycle. A read hit must coincide with the memory abort. A miss fill must coincide with delivery of the line to the processor. The bench runs back-to-back reads of one line, an aliasing pair that shares an index, and fills with return latencies of one to three cycles, including a line returned in the very lookup cycle. On every clock it judges the outputs against a behavioural model of the tag table and memory contents. It checks that the response, the abort and the forwarded line appear together, and that a later hit returns what the fill wrote.

// File: rtl/cache_pkg.sv
package cache_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOOK = 2'd1,
      ST_WAIT = 2'd2
   } ctl_state_t;
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
   parameter int IDX_W = 10,
   parameter int TAG_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_en,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [TAG_W-1:0] rd_tag,
   output logic             rd_valid,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag
);
   localparam int NUM_LINES = 1 << IDX_W;

   logic [TAG_W-1:0]     tag_mem [NUM_LINES];
   logic [NUM_LINES-1:0] valid_q;

   always_ff @(posedge clk) begin
      if (wr_en) tag_mem[wr_idx] <= wr_tag;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (wr_en) begin
         valid_q[wr_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rd_en) rd_tag <= tag_mem[rd_idx];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
      end else if (rd_en) begin
         rd_valid <= valid_q[rd_idx];
      end
   end
endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
   parameter int IDX_W      = 10,
   parameter int LINE_BYTES = 4
) (
   input  logic                    clk,
   input  logic                    rd_en,
   input  logic [IDX_W-1:0]        rd_idx,
   output logic [LINE_BYTES*8-1:0] rd_line,
   input  logic [IDX_W-1:0]        wr_idx,
   input  logic [LINE_BYTES-1:0]   wr_lane_en,
   input  logic [LINE_BYTES*8-1:0] wr_line
);
   localparam int NUM_LINES = 1 << IDX_W;

   for (genvar b = 0; b < LINE_BYTES; b++) begin : g_lane
      logic [7:0] lane_mem [NUM_LINES];

      always_ff @(posedge clk) begin
         if (wr_lane_en[b]) lane_mem[wr_idx] <= wr_line[b*8 +: 8];
      end

      always_ff @(posedge clk) begin
         if (rd_en) rd_line[b*8 +: 8] <= lane_mem[rd_idx];
      end
   end
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
   import cache_pkg::*;
#(
   parameter int OFF_W      = 2,
   parameter int IDX_W      = 10,
   parameter int TAG_W      = 12,
   parameter int LINE_BYTES = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    p_req,
   input  logic                    p_we,
   input  logic [TAG_W-1:0]        p_tag,
   input  logic [IDX_W-1:0]        p_idx,
   input  logic [OFF_W-1:0]        p_off,
   input  logic [7:0]              p_wbyte,
   output logic                    p_ready,
   output logic                    p_rvalid,
   output logic [LINE_BYTES*8-1:0] p_rdata,
   output logic                    m_abort,
   input  logic                    m_line_valid,
   input  logic [LINE_BYTES*8-1:0] m_line,
   output logic                    look_en,
   input  logic                    st_valid,
   input  logic [TAG_W-1:0]        st_tag,
   input  logic [LINE_BYTES*8-1:0] st_line,
   output logic                    tag_wr_en,
   output logic [IDX_W-1:0]        wr_idx,
   output logic [TAG_W-1:0]        wr_tag,
   output logic [LINE_BYTES-1:0]   lane_en,
   output logic [LINE_BYTES*8-1:0] lane_data
);
   localparam int LINE_W = LINE_BYTES * 8;

   ctl_state_t       state_q, state_d;
   logic [TAG_W-1:0] req_tag_q;
   logic [IDX_W-1:0] req_idx_q;
   logic [OFF_W-1:0] req_off_q;
   logic             req_we_q;
   logic [7:0]       req_byte_q;

   logic accept, tag_match, rd_hit, wr_hit, miss_pending, fill;

   assign accept       = p_req && (state_q == ST_IDLE);
   assign tag_match    = st_valid && (st_tag == req_tag_q);
   assign rd_hit       = (state_q == ST_LOOK) && !req_we_q && tag_match;
   assign wr_hit       = (state_q == ST_LOOK) && req_we_q && tag_match;
   assign miss_pending = ((state_q == ST_LOOK) && !req_we_q && !tag_match) ||
                         (state_q == ST_WAIT);
   assign fill         = miss_pending && m_line_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         req_tag_q  <= '0;
         req_idx_q  <= '0;
         req_off_q  <= '0;
         req_we_q   <= 1'b0;
         req_byte_q <= '0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            req_tag_q  <= p_tag;
            req_idx_q  <= p_idx;
            req_off_q  <= p_off;
            req_we_q   <= p_we;
            req_byte_q <= p_wbyte;
         end
      end
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (accept) state_d = ST_LOOK;
         ST_LOOK: begin
            if (req_we_q || tag_match || fill) state_d = ST_IDLE;
            else                               state_d = ST_WAIT;
         end
         ST_WAIT: if (fill) state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   assign p_ready  = (state_q == ST_IDLE);
   assign look_en  = accept;
   assign p_rvalid = rd_hit || fill;
   assign m_abort  = rd_hit;

   always_comb begin
      if (rd_hit)    p_rdata = st_line;
      else if (fill) p_rdata = m_line;
      else           p_rdata = '0;
   end

   assign tag_wr_en = fill;
   assign wr_idx    = req_idx_q;
   assign wr_tag    = req_tag_q;

   always_comb begin
      lane_en   = '0;
      lane_data = {LINE_BYTES{req_byte_q}};
      if (fill) begin
         lane_en   = '1;
         lane_data = m_line;
      end else if (wr_hit) begin
         lane_en[req_off_q] = 1'b1;
      end
   end

   logic unused_w;
   assign unused_w = ^{LINE_W[0]};
endmodule

// File: rtl/cache_lookaside_dm.sv
module cache_lookaside_dm #(
   parameter int ADDR_W     = 24,
   parameter int LINES      = 1024,
   parameter int LINE_BYTES = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    p_req,
   input  logic                    p_we,
   input  logic [ADDR_W-1:0]       p_addr,
   input  logic [7:0]              p_wbyte,
   output logic                    p_ready,
   output logic                    p_rvalid,
   output logic [LINE_BYTES*8-1:0] p_rdata,
   output logic                    m_req,
   output logic                    m_we,
   output logic [ADDR_W-1:0]       m_addr,
   output logic [7:0]              m_wbyte,
   output logic                    m_abort,
   input  logic                    m_line_valid,
   input  logic [LINE_BYTES*8-1:0] m_line
);
   localparam int OFF_W  = $clog2(LINE_BYTES);
   localparam int IDX_W  = $clog2(LINES);
   localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
   localparam int LINE_W = LINE_BYTES * 8;

   if ((LINES & (LINES - 1)) != 0 || LINES < 2) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if ((LINE_BYTES & (LINE_BYTES - 1)) != 0 || LINE_BYTES < 2) begin : g_bad_bytes
      $error("LINE_BYTES must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W too small for index and offset");
   end

   logic [TAG_W-1:0]  p_tag;
   logic [IDX_W-1:0]  p_idx;
   logic [OFF_W-1:0]  p_off;
   logic              look_en, st_valid, tag_wr_en;
   logic [TAG_W-1:0]  st_tag, wr_tag;
   logic [IDX_W-1:0]  wr_idx;
   logic [LINE_W-1:0] st_line, lane_data;
   logic [LINE_BYTES-1:0] lane_en;

   assign p_off = p_addr[OFF_W-1:0];
   assign p_idx = p_addr[OFF_W +: IDX_W];
   assign p_tag = p_addr[ADDR_W-1 -: TAG_W];

   assign m_req   = p_req && p_ready;
   assign m_we    = p_we;
   assign m_addr  = p_addr;
   assign m_wbyte = p_wbyte;

   cache_ctrl #(
      .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_BYTES(LINE_BYTES)
   ) ctrl_i (
      .clk(clk), .rst_n(rst_n),
      .p_req(p_req), .p_we(p_we), .p_tag(p_tag), .p_idx(p_idx), .p_off(p_off),
      .p_wbyte(p_wbyte), .p_ready(p_ready), .p_rvalid(p_rvalid), .p_rdata(p_rdata),
      .m_abort(m_abort), .m_line_valid(m_line_valid), .m_line(m_line),
      .look_en(look_en), .st_valid(st_valid), .st_tag(st_tag), .st_line(st_line),
      .tag_wr_en(tag_wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
      .lane_en(lane_en), .lane_data(lane_data)
   );

   cache_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) tags_i (
      .clk(clk), .rst_n(rst_n),
      .rd_en(look_en), .rd_idx(p_idx), .rd_tag(st_tag), .rd_valid(st_valid),
      .wr_en(tag_wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag)
   );

   cache_data_store #(.IDX_W(IDX_W), .LINE_BYTES(LINE_BYTES)) data_i (
      .clk(clk),
      .rd_en(look_en), .rd_idx(p_idx), .rd_line(st_line),
      .wr_idx(wr_idx), .wr_lane_en(lane_en), .wr_line(lane_data)
   );
endmodule

// File: rtl/cache_la_checker.sv
module cache_la_checker #(
   parameter int LINE_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              p_req,
   input logic              p_we,
   input logic              p_ready,
   input logic              p_rvalid,
   input logic [LINE_W-1:0] p_rdata,
   input logic              m_abort,
   input logic              m_line_valid,
   input logic [LINE_W-1:0] m_line
);
   a_r3_abort_with_data: assert property (@(posedge clk) disable iff (!rst_n)
      m_abort |-> p_rvalid);

   a_r3_hit_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      m_abort |-> $past(p_req && p_ready && !p_we));

   a_r4_rvalid_source: assert property (@(posedge clk) disable iff (!rst_n)
      p_rvalid |-> (m_abort || m_line_valid));

   a_r4_fill_forward: assert property (@(posedge clk) disable iff (!rst_n)
      (p_rvalid && !m_abort) |-> (p_rdata == m_line));

   a_r8_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (p_req && p_ready && p_we) |=> (!p_rvalid && !m_abort));

   a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (p_req && p_ready) |=> !p_ready);
endmodule

bind cache_lookaside_dm cache_la_checker #(.LINE_W(LINE_BYTES * 8)) chk_i (
   .clk(clk), .rst_n(rst_n), .p_req(p_req), .p_we(p_we), .p_ready(p_ready),
   .p_rvalid(p_rvalid), .p_rdata(p_rdata), .m_abort(m_abort),
   .m_line_valid(m_line_valid), .m_line(m_line)
);

// File: tb/cache_lookaside_dm_tb_top.sv
module cache_lookaside_dm_tb_top;
   localparam int AW = 24;
   localparam int LW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          p_req = 1'b0, p_we = 1'b0;
   logic [AW-1:0] p_addr = '0;
   logic [7:0]    p_wbyte = '0;
   logic          p_ready, p_rvalid, m_req, m_we, m_abort;
   logic [LW-1:0] p_rdata;
   logic [AW-1:0] m_addr;
   logic [7:0]    m_wbyte;
   logic          m_line_valid = 1'b0;
   logic [LW-1:0] m_line = '0;

   int total = 0;
   int failed = 0;

   logic [LW-1:0] memw [int];
   int            mtag [int];

   always #10 clk = ~clk;

   cache_lookaside_dm dut_i (
      .clk(clk), .rst_n(rst_n), .p_req(p_req), .p_we(p_we), .p_addr(p_addr),
      .p_wbyte(p_wbyte), .p_ready(p_ready), .p_rvalid(p_rvalid), .p_rdata(p_rdata),
      .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wbyte(m_wbyte),
      .m_abort(m_abort), .m_line_valid(m_line_valid), .m_line(m_line)
   );

   task automatic chk(input bit ok, input string req, input logic [LW-1:0] act,
                      input logic [LW-1:0] exp);
      total++;
      if (!ok) begin
         failed++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int line_of(input logic [AW-1:0] a);
      return int'(a >> 2);
   endfunction
   function automatic int idx_of(input logic [AW-1:0] a);
      return int'(a[11:2]);
   endfunction
   function automatic int tag_of(input logic [AW-1:0] a);
      return int'(a[23:12]);
   endfunction

   function automatic logic [LW-1:0] line_val(input int la);
      if (memw.exists(la)) return memw[la];
      return (la * 32'h9E3779B1) ^ 32'h5A5A0000;
   endfunction

   function automatic bit model_hit(input logic [AW-1:0] a);
      return mtag.exists(idx_of(a)) && mtag[idx_of(a)] == tag_of(a);
   endfunction

   task automatic rd(input logic [AW-1:0] a, input int lat, input bit noise,
                     input string req);
      bit hit;
      logic [LW-1:0] exp;
      hit = model_hit(a);
      exp = line_val(line_of(a));
      @(negedge clk);
      m_line_valid = 1'b0;
      p_req = 1'b1; p_we = 1'b0; p_addr = a;
      #1;
      chk(p_ready && m_req && m_addr == a, "R7 bus cycle mirrored", {8'h0, m_addr}, {8'h0, a});
      @(negedge clk);
      p_req = noise;
      p_addr = a ^ 24'h0F0F0C;
      if (hit) begin
         #1;
         chk(p_rvalid && m_abort, {req, " R3 hit strobes"}, {30'h0, p_rvalid, m_abort}, 32'h3);
         chk(p_rdata == exp, {req, " R3 hit data"}, p_rdata, exp);
         p_req = 1'b0;
      end else begin
         for (int c = 1; c <= lat; c++) begin
            if (c > 1) @(negedge clk);
            if (c < lat) begin
               #1;
               chk(!p_rvalid && !p_ready && !m_abort, {req, " R4 miss holds"},
                   {29'h0, p_rvalid, p_ready, m_abort}, 32'h0);
               if (noise) chk(!m_req, "R10 busy request ignored", {31'h0, m_req}, 32'h0);
            end else begin
               m_line_valid = 1'b1;
               m_line = exp;
               #1;
               chk(p_rvalid && !m_abort, {req, " R4 fill strobes"}, {30'h0, p_rvalid, m_abort}, 32'h2);
               chk(p_rdata == exp, {req, " R4 fill data"}, p_rdata, exp);
               p_req = 1'b0;
            end
         end
         mtag[idx_of(a)] = tag_of(a);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [7:0] b);
      logic [LW-1:0] v;
      @(negedge clk);
      m_line_valid = 1'b0;
      p_req = 1'b1; p_we = 1'b1; p_addr = a; p_wbyte = b;
      #1;
      chk(m_req && m_we && m_addr == a && m_wbyte == b, "R8 write through",
          {m_req, m_we, 6'h0, m_wbyte, m_addr[15:0]}, {2'b11, 6'h0, b, a[15:0]});
      @(negedge clk);
      p_req = 1'b0; p_we = 1'b0;
      #1;
      chk(!p_rvalid && !m_abort, "R8 write silent", {30'h0, p_rvalid, m_abort}, 32'h0);
      v = line_val(line_of(a));
      v[a[1:0]*8 +: 8] = b;
      memw[line_of(a)] = v;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; failed++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(p_ready && !p_rvalid && !m_abort, "R1 reset outputs",
          {29'h0, p_ready, p_rvalid, m_abort}, 32'h4);
      rst_n = 1'b1;
      @(negedge clk);
      chk(p_ready && !p_rvalid, "R1 idle after reset", {30'h0, p_ready, p_rvalid}, 32'h2);

      rd(24'h12345C, 3, 1'b1, "R1 first read misses");
      rd(24'h12345C, 1, 1'b0, "R5 refill hit");
      rd(24'h12345E, 1, 1'b0, "R2 same line other offset");
      rd(24'hABC45C, 1, 1'b0, "R6 alias evicts");
      rd(24'h12345C, 2, 1'b1, "R6 alias back misses");
      rd(24'hABC45C, 2, 1'b0, "R6 alias again misses");
      rd(24'h123800, 2, 1'b0, "R2 other index miss");
      rd(24'h123800, 1, 1'b0, "R5 other index hit");
      rd(24'hABC45C, 1, 1'b0, "R5 alias resident hit");
      wr(24'hABC45E, 8'hC3);
      rd(24'hABC45C, 1, 1'b0, "R8 write hit updates byte");
      wr(24'h777011, 8'h6D);
      rd(24'h777010, 2, 1'b0, "R9 write miss no allocate");
      rd(24'h777013, 1, 1'b0, "R5 line after write miss");
      rd(24'hFFFFFF, 1, 1'b0, "R2 top index and tag");
      rd(24'hFFFFFC, 1, 1'b0, "R2 top line hit");
      rd(24'h0003FC, 3, 1'b0, "R2 top index low tag");
      rd(24'hFFFFFD, 2, 1'b0, "R6 top index evicted");

      @(negedge clk);
      m_line_valid = 1'b0;
      #1;
      chk(p_ready && !p_rvalid, "R10 ready after completion", {30'h0, p_ready, p_rvalid}, 32'h2);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end
endmodule